// File: doc/BRIEF.md
# Instruction Address Sequencer with Return Stack

This block produces the fetch address for a small 8-bit controller core. It holds a 9-bit program counter and a two-level return-address stack. Each clock cycle the surrounding core raises at most one control strobe: step to the next address, take an absolute jump, call a subroutine, return from one, or overwrite the low address byte with a computed value. The block applies that action at the rising edge and presents the registered result on `fetch_addr`.

A call or a low-byte write only reaches the lower 256 words, because both force address bit 8 to zero. The stack keeps the two most recent return addresses. Deeper nesting silently drops the oldest one. A return pulls level 1 and moves level 2 up into it, but level 2 keeps its value. Repeated returns therefore keep landing on the same address. No overflow or underflow flag is produced.

The per-cycle action is an enumerated value chosen by a priority decoder. The states are RESET, CALL, RET, JUMP, LOWWR, STEP and HOLD, in that order of precedence. Transitions: RESET loads all ones and clears the stack. CALL pushes and branches low. RET pops. JUMP loads nine bits. LOWWR loads the low byte. STEP increments. HOLD keeps the address.

Top module: `pcseq_top`

## Requirements
- R1: A cycle with `rst` high sets `fetch_addr` to 511 (all ones) and clears both stack levels to 0, so a following return yields address 0.
- R2: With `step_en` as the only strobe, `fetch_addr` advances by one modulo 512, so 511 is followed by 0.
- R3: With no strobe asserted, `fetch_addr` keeps its value.
- R4: `jump_en` loads all nine bits of `fetch_addr` from `tgt_addr[8:0]`.
- R5: `call_en` loads `fetch_addr` with bit 8 = 0 and bits 7:0 = `tgt_addr[7:0]`. It moves stack level 1 into level 2 and writes the old `fetch_addr` + 1 (mod 512) into level 1.
- R6: `lowwr_en` loads `fetch_addr` with bit 8 = 0 and bits 7:0 = `low_val`.
- R7: `ret_en` loads `fetch_addr` from stack level 1 and copies level 2 into level 1, leaving level 2 unchanged. Further returns keep yielding the level-2 address.
- R8: After more than two nested calls, only the two most recent return addresses are retrievable.
- R9: When several strobes are asserted together, the winner is rst, then call, then return, then jump, then low write, then step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset |
| step_en | input | 1 | Advance to the next address |
| jump_en | input | 1 | Absolute jump |
| call_en | input | 1 | Subroutine call |
| ret_en | input | 1 | Subroutine return |
| lowwr_en | input | 1 | Write the low address byte |
| tgt_addr | input | 9 | Address field of the instruction |
| low_val | input | 8 | Computed low-byte value |
| fetch_addr | output | 9 | Registered fetch address |

## Verification
The bench builds the block with its defaults: a 9-bit address, an 8-bit low byte and a stack depth of 2. The small address space makes the wrap from 511 to 0 easy to reach, along with calls and low writes that arrive with bit 8 set. The two-entry stack lets three nested calls overflow it and four returns underflow it within a few cycles. Random strobe mixes, including simultaneous strobes, exercise the priority order against a bench model.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_STEP,
        ACT_LOWWR,
        ACT_JUMP,
        ACT_RET,
        ACT_CALL,
        ACT_RESET
    } act_e;
endpackage

// File: rtl/pcseq_act_sel.sv
module pcseq_act_sel
    import pcseq_pkg::*;
(
    input  logic rst,
    input  logic step_en,
    input  logic jump_en,
    input  logic call_en,
    input  logic ret_en,
    input  logic lowwr_en,
    output act_e act
);
    // R9: fixed precedence among simultaneous strobes
    always_comb begin
        if (rst)           act = ACT_RESET;
        else if (call_en)  act = ACT_CALL;
        else if (ret_en)   act = ACT_RET;
        else if (jump_en)  act = ACT_JUMP;
        else if (lowwr_en) act = ACT_LOWWR;
        else if (step_en)  act = ACT_STEP;
        else               act = ACT_HOLD;
    end
endmodule

// File: rtl/pcseq_ret_stack.sv
module pcseq_ret_stack #(
    parameter int W     = 9,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_val,
    output logic [W-1:0] top_val
);
    localparam int LAST = DEPTH - 1;

    logic [W-1:0] lvl [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (clr) begin
                lvl[i] <= '0;
            end else if (push) begin
                lvl[i] <= (i == 0) ? push_val : lvl[(i == 0) ? 0 : i - 1];
            end else if (pop) begin
                lvl[i] <= (i == LAST) ? lvl[i] : lvl[(i == LAST) ? i : i + 1];
            end
        end
    end

    assign top_val = lvl[0];

    // R5
    push_shift_chk: assert property (@(posedge clk) disable iff (rst)
        push |=> lvl[0] == $past(push_val));
    // R7
    pop_keep_bottom_chk: assert property (@(posedge clk) disable iff (rst)
        pop && !push |=> $stable(lvl[LAST]));
    // R8
    push_drop_oldest_chk: assert property (@(posedge clk) disable iff (rst)
        push |=> lvl[1] == $past(lvl[0]));
endmodule

// File: rtl/pcseq_pc_reg.sv
module pcseq_pc_reg
    import pcseq_pkg::*;
#(
    parameter int PC_W  = 9,
    parameter int LOW_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  act_e             act,
    input  logic [PC_W-1:0]  tgt_addr,
    input  logic [LOW_W-1:0] low_val,
    input  logic [PC_W-1:0]  ret_val,
    output logic [PC_W-1:0]  pc
);
    logic [PC_W-1:0] pc_nxt;

    always_comb begin
        unique case (act)
            ACT_RESET: pc_nxt = '1;
            ACT_CALL:  pc_nxt = PC_W'(tgt_addr[LOW_W-1:0]);
            ACT_RET:   pc_nxt = ret_val;
            ACT_JUMP:  pc_nxt = tgt_addr;
            ACT_LOWWR: pc_nxt = PC_W'(low_val);
            ACT_STEP:  pc_nxt = pc + 1'b1;
            default:   pc_nxt = pc;
        endcase
    end

    always_ff @(posedge clk) begin
        pc <= pc_nxt;
    end

    // R1
    reset_load_chk: assert property (@(posedge clk)
        act == ACT_RESET |=> pc == '1);
    // R4
    jump_load_chk: assert property (@(posedge clk) disable iff (rst)
        act == ACT_JUMP |=> pc == $past(tgt_addr));
    // R5
    call_high_clear_chk: assert property (@(posedge clk) disable iff (rst)
        act == ACT_CALL |=> pc[PC_W-1] == 1'b0);
    // R6
    lowwr_high_clear_chk: assert property (@(posedge clk) disable iff (rst)
        act == ACT_LOWWR |=> pc[PC_W-1] == 1'b0);
    // R7
    ret_load_chk: assert property (@(posedge clk) disable iff (rst)
        act == ACT_RET |=> pc == $past(ret_val));
    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        act == ACT_HOLD |=> $stable(pc));
endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
    import pcseq_pkg::*;
#(
    parameter int PC_W  = 9,
    parameter int LOW_W = 8,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_en,
    input  logic             jump_en,
    input  logic             call_en,
    input  logic             ret_en,
    input  logic             lowwr_en,
    input  logic [PC_W-1:0]  tgt_addr,
    input  logic [LOW_W-1:0] low_val,
    output logic [PC_W-1:0]  fetch_addr
);
    act_e            act;
    logic [PC_W-1:0] ret_val;
    logic [PC_W-1:0] link_addr;

    pcseq_act_sel u_sel (
        .rst      (rst),
        .step_en  (step_en),
        .jump_en  (jump_en),
        .call_en  (call_en),
        .ret_en   (ret_en),
        .lowwr_en (lowwr_en),
        .act      (act)
    );

    assign link_addr = fetch_addr + 1'b1;

    pcseq_ret_stack #(.W(PC_W), .DEPTH(DEPTH)) u_stack (
        .clk      (clk),
        .rst      (rst),
        .clr      (act == ACT_RESET),
        .push     (act == ACT_CALL),
        .pop      (act == ACT_RET),
        .push_val (link_addr),
        .top_val  (ret_val)
    );

    pcseq_pc_reg #(.PC_W(PC_W), .LOW_W(LOW_W)) u_pc (
        .clk      (clk),
        .rst      (rst),
        .act      (act),
        .tgt_addr (tgt_addr),
        .low_val  (low_val),
        .ret_val  (ret_val),
        .pc       (fetch_addr)
    );
endmodule

// File: tb/pcseq_top_bench.sv
module pcseq_top_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b0, step_en = 1'b0, jump_en = 1'b0, call_en = 1'b0;
    logic       ret_en = 1'b0, lowwr_en = 1'b0;
    logic [8:0] tgt_addr = '0;
    logic [7:0] low_val = '0;
    logic [8:0] fetch_addr;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    logic [8:0] m_pc = '1, m_s0 = '0, m_s1 = '0;

    always #5 clk = ~clk;

    pcseq_top u_pcseq_top (
        .clk(clk), .rst(rst), .step_en(step_en), .jump_en(jump_en),
        .call_en(call_en), .ret_en(ret_en), .lowwr_en(lowwr_en),
        .tgt_addr(tgt_addr), .low_val(low_val), .fetch_addr(fetch_addr)
    );

    function automatic string req_of(logic r, logic c, logic t, logic j, logic w, logic s);
        if (int'(r) + int'(c) + int'(t) + int'(j) + int'(w) + int'(s) > 1) return "R9";
        if (r) return "R1";
        if (c) return "R5/R8";
        if (t) return "R7";
        if (j) return "R4";
        if (w) return "R6";
        if (s) return "R2";
        return "R3";
    endfunction

    task automatic model(logic r, logic c, logic t, logic j, logic w, logic s,
                         logic [8:0] a, logic [7:0] v);
        if (r) begin m_pc = '1; m_s0 = '0; m_s1 = '0; end
        else if (c) begin m_s1 = m_s0; m_s0 = m_pc + 9'd1; m_pc = {1'b0, a[7:0]}; end
        else if (t) begin m_pc = m_s0; m_s0 = m_s1; end
        else if (j) m_pc = a;
        else if (w) m_pc = {1'b0, v};
        else if (s) m_pc = m_pc + 9'd1;
    endtask

    task automatic step(logic r, logic c, logic t, logic j, logic w, logic s,
                        logic [8:0] a, logic [7:0] v);
        string tag;
        tag = req_of(r, c, t, j, w, s);
        rst = r; call_en = c; ret_en = t; jump_en = j; lowwr_en = w; step_en = s;
        tgt_addr = a; low_val = v;
        model(r, c, t, j, w, s, a, v);
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (fetch_addr !== m_pc) begin
            fails++;
            $display("FAIL %s: fetch_addr=%0d expected=%0d", tag, fetch_addr, m_pc);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        // R1 reset state
        step(1, 0, 0, 0, 0, 0, 9'd0, 8'd0);
        // R2 wrap 511 -> 0
        step(0, 0, 0, 0, 0, 1, 9'd0, 8'd0);
        // R1 cleared stack: return gives 0
        step(0, 0, 1, 0, 0, 0, 9'd0, 8'd0);
        // R3 hold
        step(0, 0, 0, 0, 0, 0, 9'd77, 8'd5);
        // R4 jump into upper half
        step(0, 0, 0, 1, 0, 0, 9'd300, 8'd0);
        // R5 call with bit 8 set in field
        step(0, 1, 0, 0, 0, 0, 9'd400, 8'd0);
        // R6 low write
        step(0, 0, 0, 0, 1, 0, 9'd0, 8'd200);
        // R8 three nested calls then four returns
        step(0, 0, 0, 1, 0, 0, 9'd500, 8'd0);
        step(0, 1, 0, 0, 0, 0, 9'd10, 8'd0);
        step(0, 1, 0, 0, 0, 0, 9'd20, 8'd0);
        step(0, 1, 0, 0, 0, 0, 9'd30, 8'd0);
        for (int k = 0; k < 4; k++) step(0, 0, 1, 0, 0, 0, 9'd0, 8'd0);
        // R9 all strobes but reset
        step(0, 1, 1, 1, 1, 1, 9'd99, 8'd3);
        step(0, 0, 1, 1, 1, 1, 9'd99, 8'd3);
        step(0, 0, 0, 1, 1, 1, 9'd99, 8'd3);
        step(0, 0, 0, 0, 1, 1, 9'd99, 8'd3);
        step(1, 1, 1, 1, 1, 1, 9'd99, 8'd3);
        // random mix
        for (int k = 0; k < 3000; k++) begin
            int p;
            p = int'($urandom % 100);
            step(p < 2, (p % 7) == 1, (p % 5) == 2, (p % 11) == 3, (p % 13) == 4,
                 p >= 40, 9'($urandom), 8'($urandom));
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule